// File: doc/BRIEF.md
# UART Status Flags and Data Holding Register

This block keeps the event and error flags of a UART together with its data holding registers, and it applies the rules that raise and drop each flag. The shift engines, the baud generator and the noise sampler sit outside. They report through single-cycle event pulses: transmit word handed to the shifter, frame finished, word received, idle line, noise, framing error and parity error. The block derives the overrun event itself, from a reception that completes while the previous word is still unread.

Software reaches the block through a plain strobe port with one select line. The select chooses between the status register and the data register. Some flags drop on a direct access. The others drop only after a two-step sequence: a status read taken while the flag was set, then a later data register access of the correct kind. Each such flag has its own "seen" latch, so a flag that rises after the status read survives the following data access.

Writes to the data register fill the transmit holding word. When parity is on, the most significant data bit is replaced by a computed parity bit. Reads of the data register return the received holding word.

Top module: `uart_flag_regs`

## Requirements
- R1: After reset, a status read returns 0x000000C0 (transmit-empty and transmit-complete set) and a data read returns 0. Status bit positions: 7 transmit-empty, 6 transmit-complete, 5 receive-full, 4 idle, 3 overrun, 2 noise, 1 framing, 0 parity.
- R2: Transmit-empty is set by `ev_tx_load`, and any data register write clears it on the next edge without a prior status read.
- R3: Transmit-complete is set by `ev_tx_done`. It clears on a data write that follows a status read taken while it was set, or on a status write with wdata bit 6 = 0. Status writes with bit 7 = 0 leave transmit-empty unchanged.
- R4: `ev_rx_done` with receive-full clear loads `rx_word` into the receive holding word and sets receive-full. A data read, or a status write with wdata bit 5 = 0, clears receive-full.
- R5: `ev_rx_done` while receive-full is set raises overrun and leaves the receive holding word unchanged.
- R6: Idle, overrun, noise, framing and parity clear only on a data read that follows a status read taken while the flag was set. Status writes and data writes leave them unchanged.
- R7: A flag that rises after the status read is not cleared by the data access that completes that read's sequence.
- R8: When a set event and a clear arrive in the same cycle, the flag is 1 afterwards.
- R9: With `par_en`=1 and `wide_frame`=1, tx_word = {p, w[7:0]}. With `par_en`=1 and `wide_frame`=0, tx_word = {0, p, w[6:0]}. Here p is the XOR of those data bits, inverted when `par_odd`=1. With `par_en`=0, tx_word = w[8:0].
- R10: Bits 31..9 of a data read and bits 31..8 of a status read are 0.
- R11: `irq` is high exactly when some flag bit and the `irq_en` bit at the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects status register, 1 selects data register |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register (combinational) |
| ev_tx_load | input | 1 | Transmit word taken by the shifter |
| ev_tx_done | input | 1 | Transmit frame finished |
| ev_rx_done | input | 1 | Received word ready on rx_word |
| rx_word | input | 9 | Received data word |
| ev_idle | input | 1 | Idle line detected |
| ev_noise | input | 1 | Noise detected on a frame |
| ev_frame_err | input | 1 | Low stop bit, excessive noise or break |
| ev_parity_err | input | 1 | Parity mismatch on a received frame |
| par_en | input | 1 | Parity substitution on transmit |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| wide_frame | input | 1 | 1 for 8 data bits + parity, 0 for 7 + parity |
| irq_en | input | 8 | Per-flag interrupt enables, same bit positions as status |
| tx_word | output | 9 | Transmit holding word after parity substitution |
| irq | output | 1 | Level interrupt |

## Verification
Several rules are checked on every cycle by the assertions:
- a set event always leaves its flag high;
- a flag with no recorded status read is never dropped by a data access;
- an overrun never disturbs the receive holding word;
- a data write always empties transmit-empty;
- upper read bits stay zero.

Other behaviour needs the bench's ordered scenarios:
- the full two-step clearing sequence;
- a flag raised between the status read and the data access surviving it;
- status writes that must leave read-only flags alone;
- the parity substitution values in both frame widths and both polarities.

// File: rtl/uflag_pkg.sv
package uflag_pkg;
  localparam int NFLAG    = 8;
  localparam int DATA_W   = 9;
  localparam int BUS_W    = 32;
  // flag bit positions
  localparam int F_PAR    = 0;
  localparam int F_FRM    = 1;
  localparam int F_NOISE  = 2;
  localparam int F_OVR    = 3;
  localparam int F_IDLE   = 4;
  localparam int F_RXF    = 5;
  localparam int F_TC     = 6;
  localparam int F_TXE    = 7;
  // per-flag behaviour masks
  localparam logic [NFLAG-1:0] RST_MASK   = 8'hC0; // reset value
  localparam logic [NFLAG-1:0] SEQRD_MASK = 8'h1F; // status read then data read
  localparam logic [NFLAG-1:0] SEQWR_MASK = 8'h40; // status read then data write
  localparam logic [NFLAG-1:0] WR0_MASK   = 8'h60; // direct clear by writing 0
  typedef enum logic {SEL_STS = 1'b0, SEL_DATA = 1'b1} reg_sel_e;
endpackage

// File: rtl/uflag_cell.sv
module uflag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic sts_rd_i,
  input  logic seq_acc_i,
  input  logic soft_clr_i,
  output logic flag_o
);
  logic flag_q, flag_d, seen_q, seen_d, clr, upd;

  assign clr = soft_clr_i | (seq_acc_i & seen_q);
  assign upd = set_i | clr | sts_rd_i;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr);
    if (clr)                 seen_d = 1'b0;
    else if (sts_rd_i)       seen_d = flag_q;
    else                     seen_d = seen_q & flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      seen_q <= 1'b0;
    end else if (upd) begin
      flag_q <= flag_d;
      seen_q <= seen_d;
    end
  end

  assign flag_o = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R7
  no_unseen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !seen_q && !soft_clr_i && !sts_rd_i) |=> flag_o);
endmodule

// File: rtl/uflag_txpar.sv
module uflag_txpar #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] tx_word_o
);
  localparam int NW = DATA_W - 1;  // data bits in a wide frame
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              p_wide, p_narrow;

  assign p_wide   = (^wdata_i[NW-1:0]) ^ par_odd_i;
  assign p_narrow = (^wdata_i[NW-2:0]) ^ par_odd_i;

  always_comb begin
    if (!par_en_i)  hold_d = wdata_i;
    else if (wide_i) hold_d = {p_wide, wdata_i[NW-1:0]};
    else             hold_d = {1'b0, p_narrow, wdata_i[NW-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (load_i) hold_q <= hold_d;
  end

  assign tx_word_o = hold_q;

  // R9
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && par_en_i && !wide_i) |=> !tx_word_o[DATA_W-1]);
endmodule

// File: rtl/uart_flag_regs.sv
module uart_flag_regs
  import uflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ev_tx_load,
  input  logic        ev_tx_done,
  input  logic        ev_rx_done,
  input  logic [8:0]  rx_word,
  input  logic        ev_idle,
  input  logic        ev_noise,
  input  logic        ev_frame_err,
  input  logic        ev_parity_err,
  input  logic        par_en,
  input  logic        par_odd,
  input  logic        wide_frame,
  input  logic [7:0]  irq_en,
  output logic [8:0]  tx_word,
  output logic        irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [NFLAG-1:0]  flags, set_v, seq_v, soft_v;
  logic              sts_rd, sts_wr, dat_rd, dat_wr, rx_load;
  logic [DATA_W-1:0] rx_hold_q, rx_hold_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign sts_rd = rd_stb & (reg_sel == SEL_STS);
  assign sts_wr = wr_stb & (reg_sel == SEL_STS);
  assign dat_rd = rd_stb & (reg_sel == SEL_DATA);
  assign dat_wr = wr_stb & (reg_sel == SEL_DATA);

  always_comb begin
    set_v          = '0;
    set_v[F_TXE]   = ev_tx_load;
    set_v[F_TC]    = ev_tx_done;
    set_v[F_RXF]   = ev_rx_done;
    set_v[F_IDLE]  = ev_idle;
    set_v[F_OVR]   = ev_rx_done & flags[F_RXF];
    set_v[F_NOISE] = ev_noise;
    set_v[F_FRM]   = ev_frame_err;
    set_v[F_PAR]   = ev_parity_err;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      seq_v[i]  = (SEQRD_MASK[i] & dat_rd) | (SEQWR_MASK[i] & dat_wr);
      soft_v[i] = WR0_MASK[i] & sts_wr & ~wdata[i];
      if (i == F_TXE) soft_v[i] = dat_wr;
      if (i == F_RXF) soft_v[i] = soft_v[i] | dat_rd;
    end
    uflag_cell #(.RST_VAL(RST_MASK[i])) u_cell (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .set_i     (set_v[i]),
      .sts_rd_i  (sts_rd),
      .seq_acc_i (seq_v[i]),
      .soft_clr_i(soft_v[i]),
      .flag_o    (flags[i])
    );
  end

  // receive holding word: kept on overrun
  assign rx_load   = ev_rx_done & ~flags[F_RXF];
  assign rx_hold_d = rx_word;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     rx_hold_q <= '0;
    else if (rx_load) rx_hold_q <= rx_hold_d;
  end

  uflag_txpar #(.DATA_W(DATA_W)) u_txpar (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load_i   (dat_wr),
    .wdata_i  (wdata[DATA_W-1:0]),
    .par_en_i (par_en),
    .par_odd_i(par_odd),
    .wide_i   (wide_frame),
    .tx_word_o(tx_word)
  );

  always_comb begin
    if (reg_sel == SEL_STS) rdata = {{(BUS_W-NFLAG){1'b0}}, flags};
    else                    rdata = {{(BUS_W-DATA_W){1'b0}}, rx_hold_q};
  end

  assign irq = |(flags & irq_en);

  // R5
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev_rx_done && flags[F_RXF]) |=> ($stable(rx_hold_q) && flags[F_OVR]));

  // R4
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ev_rx_done && !flags[F_RXF]) |=> (rx_hold_q == $past(rx_word) && flags[F_RXF]));

  // R2
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dat_wr && !ev_tx_load) |=> !flags[F_TXE]);

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_stb |-> (rdata[BUS_W-1:DATA_W] == '0));
endmodule

// File: tb/test_uart_flag_regs.sv
module test_uart_flag_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, rd_stb, wr_stb;
  logic [31:0] wdata, rdata;
  logic        ev_tx_load, ev_tx_done, ev_rx_done;
  logic [8:0]  rx_word, tx_word;
  logic        ev_idle, ev_noise, ev_frame_err, ev_parity_err;
  logic        par_en, par_odd, wide_frame, irq;
  logic [7:0]  irq_en;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_flag_regs i_uart_flag_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .ev_tx_load(ev_tx_load), .ev_tx_done(ev_tx_done),
    .ev_rx_done(ev_rx_done), .rx_word(rx_word), .ev_idle(ev_idle), .ev_noise(ev_noise),
    .ev_frame_err(ev_frame_err), .ev_parity_err(ev_parity_err), .par_en(par_en),
    .par_odd(par_odd), .wide_frame(wide_frame), .irq_en(irq_en), .tx_word(tx_word), .irq(irq)
  );

  // monitor: compare every read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_stb) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read: got %08h expected none", rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata !== e.exp) begin
          n_fail++;
          $display("FAIL %s: got %08h expected %08h", e.tag, rdata, e.exp);
        end
      end
    end
  end

  // ev bits: 0 tx_load, 1 tx_done, 2 rx_done, 3 idle, 4 noise, 5 frame, 6 parity
  task automatic do_cycle(input logic sel, input logic rd, input logic wr,
                          input logic [31:0] wd, input logic [6:0] ev,
                          input logic [8:0] rxw, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_sel = sel; rd_stb = rd; wr_stb = wr; wdata = wd; rx_word = rxw;
    {ev_parity_err, ev_frame_err, ev_noise, ev_idle, ev_rx_done, ev_tx_done, ev_tx_load} = ev;
    if (rd) sb_q.push_back('{exp: exp, tag: tag});
    @(posedge clk); #1;
    rd_stb = 1'b0; wr_stb = 1'b0;
    {ev_parity_err, ev_frame_err, ev_noise, ev_idle, ev_rx_done, ev_tx_done, ev_tx_load} = '0;
  endtask

  task automatic rd_sts(input logic [7:0] exp, input string tag);
    do_cycle(1'b0, 1'b1, 1'b0, 32'h0, 7'h0, 9'h0, {24'h0, exp}, tag);
  endtask
  task automatic rd_dat(input logic [8:0] exp, input string tag);
    do_cycle(1'b1, 1'b1, 1'b0, 32'h0, 7'h0, 9'h0, {23'h0, exp}, tag);
  endtask
  task automatic ev_only(input logic [6:0] ev, input logic [8:0] rxw);
    do_cycle(1'b0, 1'b0, 1'b0, 32'h0, ev, rxw, 32'h0, "");
  endtask

  task automatic chk_val(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr_tx(input logic [8:0] w, input logic [8:0] exp, input string tag);
    do_cycle(1'b1, 1'b0, 1'b1, {23'h7FFFFF, w}, 7'h0, 9'h0, 32'h0, "");
    @(negedge clk);
    chk_val({23'h0, tx_word}, {23'h0, exp}, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wdata = '0; rx_word = '0;
    ev_tx_load = 0; ev_tx_done = 0; ev_rx_done = 0; ev_idle = 0; ev_noise = 0;
    ev_frame_err = 0; ev_parity_err = 0; par_en = 0; par_odd = 0; wide_frame = 1; irq_en = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values, R10 upper bits zero
    rd_dat(9'h000, "R1 data reset");
    rd_sts(8'hC0, "R1 status reset");
    // R3 status read seen TC, data write clears TC; R2 write clears TXE
    wr_tx(9'h1A5, 9'h1A5, "R9 no parity passthrough");
    rd_sts(8'h00, "R2 R3 after data write");
    // R2 set, R3 set then cleared by writing 0 to bit 6 (bit 7 ignored)
    ev_only(7'b0000011, 9'h0);
    rd_sts(8'hC0, "R2 R3 set by events");
    do_cycle(1'b0, 1'b0, 1'b1, 32'h0000003F, 7'h0, 9'h0, 32'h0, "");
    rd_sts(8'h80, "R3 write-zero clear, TXE kept");

    // R9 parity substitution
    par_en = 1; wide_frame = 1; par_odd = 0;
    wr_tx(9'h103, 9'h003, "R9 wide even p0");
    wr_tx(9'h007, 9'h107, "R9 wide even p1");
    par_odd = 1;
    wr_tx(9'h007, 9'h007, "R9 wide odd");
    wide_frame = 0; par_odd = 0;
    wr_tx(9'h1FF, 9'h0FF, "R9 narrow even");
    par_odd = 1;
    wr_tx(9'h1FF, 9'h07F, "R9 narrow odd");
    par_en = 0; wide_frame = 1; par_odd = 0;
    ev_only(7'b0000001, 9'h0);

    // R4 receive
    ev_only(7'b0000100, 9'h155);
    rd_sts(8'hA0, "R4 receive-full set");
    rd_dat(9'h155, "R4 received word");
    rd_sts(8'h80, "R4 cleared by data read");

    // R5 overrun keeps data
    ev_only(7'b0000100, 9'h0AA);
    ev_only(7'b0000100, 9'h033);
    rd_sts(8'hA8, "R5 overrun flagged");
    rd_dat(9'h0AA, "R5 held word preserved");
    rd_sts(8'h80, "R5 R6 overrun cleared by sequence");

    // R7 flag raised after status read survives; R6 data write does not clear
    ev_only(7'b0010000, 9'h0);
    rd_sts(8'h84, "R6 noise set");
    ev_only(7'b1000000, 9'h0);
    rd_dat(9'h0AA, "R7 data read");
    rd_sts(8'h81, "R7 late parity kept, noise cleared");
    do_cycle(1'b1, 1'b0, 1'b1, 32'h0, 7'h0, 9'h0, 32'h0, "");
    rd_sts(8'h01, "R6 data write leaves parity");
    rd_dat(9'h0AA, "R6 data read");
    rd_sts(8'h00, "R6 parity cleared by sequence");

    // R8 set wins over write-zero clear of receive-full
    do_cycle(1'b0, 1'b0, 1'b1, 32'h000000DF, 7'b0000100, 9'h1C3, 32'h0, "");
    rd_sts(8'h20, "R8 receive-full kept");
    rd_dat(9'h1C3, "R8 word loaded");
    // R6 idle and framing: status write ignored
    ev_only(7'b0101000, 9'h0);
    rd_sts(8'h12, "R6 idle framing set");
    do_cycle(1'b0, 1'b0, 1'b1, 32'h0, 7'h0, 9'h0, 32'h0, "");
    rd_sts(8'h12, "R6 status write ignored");
    rd_dat(9'h1C3, "R6 data read");
    rd_sts(8'h00, "R6 idle framing cleared");

    // R8 transmit-complete set beats sequence clear
    ev_only(7'b0000010, 9'h0);
    rd_sts(8'h40, "R3 TC set");
    do_cycle(1'b1, 1'b0, 1'b1, 32'h0, 7'b0000010, 9'h0, 32'h0, "");
    rd_sts(8'h40, "R8 TC kept");

    // R11 interrupt
    irq_en = 8'h20;
    @(negedge clk);
    chk_val({31'h0, irq}, 32'h0, "R11 irq low");
    ev_only(7'b0000100, 9'h011);
    @(negedge clk);
    chk_val({31'h0, irq}, 32'h1, "R11 irq high");
    irq_en = 8'h10;
    @(negedge clk);
    chk_val({31'h0, irq}, 32'h0, "R11 irq masked");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule